// File: doc/BRIEF.md
# Audio DMA Channel Register Block

This block holds the per-channel state of a descriptor-driven audio DMA engine. One instance serves a single stream: capture, playback or microphone. It keeps a descriptor-list base pointer and three descriptor indices. The indices are the one being worked on, the one fetched ahead, and the last one software has marked valid. It also keeps a countdown of samples left in the current buffer, a five-bit status register and a five-bit control register. Software reaches these through a byte-enabled 32-bit register port.

The DMA datapath is not part of this block. It talks to the block through strobes:

- a next-buffer strobe, which carries the length of the new buffer;
- a per-sample tick;
- a buffer-complete strobe, which carries the completion-interrupt flag from bit 31 of the descriptor's control word (descriptors are 8 bytes: a pointer word, then a control/length word);
- a FIFO-error strobe.

From these the block:

- steps the indices;
- sets and clears the status bits;
- drives a level interrupt, gated per source by control enables;
- runs a self-timed register reset that keeps the interrupt enables.

Top module: `adma_chan_regs`

## Requirements
- R1: After the asynchronous reset, the base pointer, all indices, the position count and the control register are zero. Status reads 0x0001 (halted set), and `irq` is low.
- R2: Aligned reads return these words:
  - 0x00: the base pointer.
  - 0x04: the current index in [7:0], the last-valid index in [15:8] and status in [31:16].
  - 0x08: the position count in [15:0], the prefetched index in [23:16] and control in [31:24].
  - 0x0C: zero.
  - Indices are zero-extended from 5 bits.
- R3: Register writes, each written byte qualified by its byte enable:
  - The base pointer takes any enabled byte of a write to 0x00. Its bits [2:0] always read zero.
  - The last-valid index takes `bus_wdata[12:8]` when byte 1 of 0x04 is written.
  - Control takes `bus_wdata[28:24]` when byte 3 of 0x08 is written.
  - The current index, the prefetched index and the position count ignore bus writes.
- R4: Writing byte 2 of 0x04 with a one in `bus_wdata[20:18]` clears status bits 4, 3 and 2 respectively. Status bits 1:0 ignore writes. A set event in the same cycle wins over the clear.
- R5: Status bit 0 (halted) equals the inverse of control bit 0 (run) as it stood one cycle earlier.
- R6: A next-buffer strobe has three effects. The current index takes the prefetched index. The prefetched index becomes (prefetched + 1) mod 32. The position count loads `nxt_len`.
- R7: A sample tick decrements a non-zero position count and leaves zero at zero. A next-buffer strobe in the same cycle wins.
- R8: A buffer-complete strobe with `done_ioc` high sets status bit 3. If the current index equals the last-valid index when the strobe arrives, it also sets status bits 2 and 1.
- R9: A FIFO-error strobe sets status bit 4.
- R10: `irq` is high exactly when (status bit 2 and control bit 2) or (status bit 3 and control bit 4). Status bit 4 never raises it.
- R11: Writing control bit 1 starts a register reset:
  - Control bit 1 reads one for exactly one cycle.
  - At the next edge, the base pointer, all indices and the position count clear, and control keeps only bits 4:2.
  - In that cycle, bus writes, next-buffer strobes and sample ticks are ignored.
- R12: Status bit 1 is cleared by a write to the last-valid index or by a next-buffer strobe, unless it is set again in the same cycle.
- R13: An access whose `bus_addr[1:0]` is non-zero writes nothing and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Byte address within the channel |
| bus_be | input | 4 | Byte enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| nxt_buf | input | 1 | Advance to the prefetched descriptor |
| nxt_len | input | POS_W | Sample count of the buffer being entered |
| smp_tick | input | 1 | One sample moved |
| done_stb | input | 1 | Current buffer finished |
| done_ioc | input | 1 | Completion-interrupt flag of the finished descriptor |
| fifo_err | input | 1 | FIFO under- or overrun |
| irq | output | 1 | Channel interrupt, level |

## Verification
Most state faults in this block show at the port one edge after they arise. A wrong index step or a missed position reload shows up in the very next read of 0x04 or 0x08. A status bit that is set late, or cleared on the wrong write, flips `irq` in the same cycle it goes wrong, provided its enable is on. The self-timed reset is the sharpest case. It is visible only for the single cycle when control bit 1 reads one, and its effect on the halted bit arrives a further edge later. So the reference model is compared on every clock, not just at the end of each directed step.

// File: rtl/adma_chan_pkg.sv
package adma_chan_pkg;

  localparam int SR_W = 5;
  localparam int CR_W = 5;

  // status bit positions (software decodes them)
  localparam int SR_HALT     = 0;
  localparam int SR_CELV     = 1;
  localparam int SR_LAST_INT = 2;
  localparam int SR_CMPL_INT = 3;
  localparam int SR_FIFO_ERR = 4;

  // control bit positions
  localparam int CR_RUN     = 0;
  localparam int CR_RST     = 1;
  localparam int CR_LAST_IE = 2;
  localparam int CR_FIFO_IE = 3;
  localparam int CR_CMPL_IE = 4;

  localparam logic [CR_W-1:0] CR_KEEP_MASK = 5'b11100;
  localparam logic [SR_W-1:0] SR_RST_VAL   = 5'b00001;

  typedef enum logic [1:0] {
    WSEL_BASE  = 2'd0,
    WSEL_STAT  = 2'd1,
    WSEL_POS   = 2'd2,
    WSEL_SPARE = 2'd3
  } wsel_e;

  function automatic logic irq_of(input logic [SR_W-1:0] sr, input logic [CR_W-1:0] cr);
    return (sr[SR_LAST_INT] & cr[CR_LAST_IE]) | (sr[SR_CMPL_INT] & cr[CR_CMPL_IE]);
  endfunction

  function automatic logic [31:0] pack_stat(input logic [7:0] civ, input logic [7:0] lvi,
                                            input logic [SR_W-1:0] sr);
    return {11'd0, sr, lvi, civ};
  endfunction

  function automatic logic [31:0] pack_pos(input logic [15:0] picb, input logic [7:0] piv,
                                           input logic [CR_W-1:0] cr);
    return {3'd0, cr, piv, picb};
  endfunction

endpackage

// File: rtl/adma_bus_decode.sv
module adma_bus_decode
  import adma_chan_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int POS_W = 16
) (
  input  logic             bus_wr,
  input  logic [3:0]       bus_addr,
  input  logic [3:0]       bus_be,
  input  logic [31:0]      bus_wdata,
  input  logic             rst_cyc,
  input  logic [31:0]      base_q,
  input  logic [IDX_W-1:0] civ_q,
  input  logic [IDX_W-1:0] lvi_q,
  input  logic [IDX_W-1:0] piv_q,
  input  logic [POS_W-1:0] picb_q,
  input  logic [SR_W-1:0]  sr_q,
  input  logic [CR_W-1:0]  cr_q,
  output logic [3:0]       wr_base_be,
  output logic             wr_lvi,
  output logic [IDX_W-1:0] lvi_wdata,
  output logic [2:0]       sr_clr,
  output logic             wr_cr,
  output logic [CR_W-1:0]  cr_wdata,
  output logic [31:0]      bus_rdata
);

  wsel_e wsel;
  logic  aligned;
  logic  wr_ok;
  logic  unused_wdata;

  assign wsel    = wsel_e'(bus_addr[3:2]);
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_ok   = bus_wr & aligned & ~rst_cyc;

  assign wr_base_be = (wr_ok && wsel == WSEL_BASE) ? bus_be : 4'b0000;
  assign wr_lvi     = wr_ok && wsel == WSEL_STAT && bus_be[1];
  assign lvi_wdata  = IDX_W'(bus_wdata[15:8]);
  assign sr_clr     = (wr_ok && wsel == WSEL_STAT && bus_be[2]) ? bus_wdata[20:18] : 3'b000;
  assign wr_cr      = wr_ok && wsel == WSEL_POS && bus_be[3];
  assign cr_wdata   = bus_wdata[28:24];

  assign unused_wdata = ^{bus_wdata[31:29], bus_wdata[23:21], bus_wdata[17:16], bus_wdata[7:0]};

  always_comb begin
    bus_rdata = 32'd0;
    if (aligned) begin
      unique case (wsel)
        WSEL_BASE:  bus_rdata = base_q;
        WSEL_STAT:  bus_rdata = pack_stat(8'(civ_q), 8'(lvi_q), sr_q);
        WSEL_POS:   bus_rdata = pack_pos(16'(picb_q), 8'(piv_q), cr_q);
        WSEL_SPARE: bus_rdata = 32'd0;
        default:    bus_rdata = 32'd0;
      endcase
    end
  end

endmodule

// File: rtl/adma_index_unit.sv
module adma_index_unit #(
  parameter int IDX_W      = 5,
  parameter int POS_W      = 16,
  parameter int BASE_ALIGN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_cyc,
  input  logic [3:0]       wr_base_be,
  input  logic [31:0]      base_wdata,
  input  logic             wr_lvi,
  input  logic [IDX_W-1:0] lvi_wdata,
  input  logic             nxt_ev,
  input  logic [POS_W-1:0] nxt_len,
  input  logic             smp_tick,
  output logic [31:0]      base_q,
  output logic [IDX_W-1:0] civ_q,
  output logic [IDX_W-1:0] lvi_q,
  output logic [IDX_W-1:0] piv_q,
  output logic [POS_W-1:0] picb_q,
  output logic             idx_hit
);

  localparam logic [31:0] ALIGN_MASK = ~((32'd1 << BASE_ALIGN) - 32'd1);

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] i);
    return i + 1'b1;
  endfunction

  function automatic logic [POS_W-1:0] count_down(input logic [POS_W-1:0] p);
    return (p == '0) ? p : p - 1'b1;
  endfunction

  logic [31:0] base_nxt;

  for (genvar b = 0; b < 4; b++) begin : g_base_byte
    assign base_nxt[8*b +: 8] = wr_base_be[b] ? base_wdata[8*b +: 8] : base_q[8*b +: 8];
  end

  assign idx_hit = (civ_q == lvi_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      civ_q  <= '0;
      lvi_q  <= '0;
      piv_q  <= '0;
      picb_q <= '0;
    end else if (rst_cyc) begin
      base_q <= '0;
      civ_q  <= '0;
      lvi_q  <= '0;
      piv_q  <= '0;
      picb_q <= '0;
    end else begin
      base_q <= base_nxt & ALIGN_MASK;
      if (wr_lvi) lvi_q <= lvi_wdata;
      if (nxt_ev) begin
        civ_q  <= piv_q;
        piv_q  <= step_idx(piv_q);
        picb_q <= nxt_len;
      end else if (smp_tick) begin
        picb_q <= count_down(picb_q);
      end
    end
  end

endmodule

// File: rtl/adma_ctrl_status.sv
module adma_ctrl_status
  import adma_chan_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_cr,
  input  logic [CR_W-1:0] cr_wdata,
  input  logic [2:0]      sr_clr,
  input  logic            wr_lvi,
  input  logic            nxt_ev,
  input  logic            done_stb,
  input  logic            done_ioc,
  input  logic            idx_hit,
  input  logic            fifo_err,
  output logic [CR_W-1:0] cr_q,
  output logic [SR_W-1:0] sr_q,
  output logic            rst_cyc,
  output logic            last_hit_ev,
  output logic            irq
);

  logic [2:0]      int_set;
  logic            celv_clr;
  logic [SR_W-1:0] sr_nxt;

  assign rst_cyc     = cr_q[CR_RST];
  assign last_hit_ev = done_stb & idx_hit;
  assign int_set     = {fifo_err, done_stb & done_ioc, last_hit_ev};
  assign celv_clr    = wr_lvi | nxt_ev;

  always_comb begin
    sr_nxt             = sr_q;
    sr_nxt[SR_HALT]    = ~cr_q[CR_RUN];
    sr_nxt[4:2]        = (sr_q[4:2] & ~sr_clr) | int_set;
    if (last_hit_ev)   sr_nxt[SR_CELV] = 1'b1;
    else if (celv_clr) sr_nxt[SR_CELV] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_q <= '0;
      sr_q <= SR_RST_VAL;
    end else begin
      sr_q <= sr_nxt;
      if (rst_cyc)    cr_q <= cr_q & CR_KEEP_MASK;
      else if (wr_cr) cr_q <= cr_wdata;
    end
  end

  assign irq = irq_of(sr_q, cr_q);

endmodule

// File: rtl/adma_chan_regs.sv
module adma_chan_regs
  import adma_chan_pkg::*;
#(
  parameter int IDX_W      = 5,
  parameter int POS_W      = 16,
  parameter int BASE_ALIGN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [3:0]       bus_addr,
  input  logic [3:0]       bus_be,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             nxt_buf,
  input  logic [POS_W-1:0] nxt_len,
  input  logic             smp_tick,
  input  logic             done_stb,
  input  logic             done_ioc,
  input  logic             fifo_err,
  output logic             irq
);

  logic [31:0]      base_q;
  logic [IDX_W-1:0] civ_q, lvi_q, piv_q, lvi_wdata;
  logic [POS_W-1:0] picb_q;
  logic [SR_W-1:0]  sr_q;
  logic [CR_W-1:0]  cr_q, cr_wdata;
  logic [3:0]       wr_base_be;
  logic [2:0]       sr_clr;
  logic             wr_lvi, wr_cr, rst_cyc, nxt_ev, smp_ev, idx_hit, last_hit_ev;

  assign nxt_ev = nxt_buf & ~rst_cyc;
  assign smp_ev = smp_tick & ~rst_cyc;

  adma_bus_decode #(.IDX_W(IDX_W), .POS_W(POS_W)) u_dec (
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .rst_cyc(rst_cyc), .base_q(base_q), .civ_q(civ_q), .lvi_q(lvi_q), .piv_q(piv_q),
    .picb_q(picb_q), .sr_q(sr_q), .cr_q(cr_q), .wr_base_be(wr_base_be), .wr_lvi(wr_lvi),
    .lvi_wdata(lvi_wdata), .sr_clr(sr_clr), .wr_cr(wr_cr), .cr_wdata(cr_wdata),
    .bus_rdata(bus_rdata)
  );

  adma_index_unit #(.IDX_W(IDX_W), .POS_W(POS_W), .BASE_ALIGN(BASE_ALIGN)) u_idx (
    .clk(clk), .rst_n(rst_n), .rst_cyc(rst_cyc), .wr_base_be(wr_base_be),
    .base_wdata(bus_wdata), .wr_lvi(wr_lvi), .lvi_wdata(lvi_wdata), .nxt_ev(nxt_ev),
    .nxt_len(nxt_len), .smp_tick(smp_ev), .base_q(base_q), .civ_q(civ_q), .lvi_q(lvi_q),
    .piv_q(piv_q), .picb_q(picb_q), .idx_hit(idx_hit)
  );

  adma_ctrl_status u_cs (
    .clk(clk), .rst_n(rst_n), .wr_cr(wr_cr), .cr_wdata(cr_wdata), .sr_clr(sr_clr),
    .wr_lvi(wr_lvi), .nxt_ev(nxt_ev), .done_stb(done_stb), .done_ioc(done_ioc),
    .idx_hit(idx_hit), .fifo_err(fifo_err), .cr_q(cr_q), .sr_q(sr_q), .rst_cyc(rst_cyc),
    .last_hit_ev(last_hit_ev), .irq(irq)
  );

endmodule

// File: rtl/adma_chan_regs_chk.sv
module adma_chan_regs_chk #(
  parameter int IDX_W = 5,
  parameter int POS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      base_q,
  input logic [IDX_W-1:0] civ_q,
  input logic [IDX_W-1:0] lvi_q,
  input logic [IDX_W-1:0] piv_q,
  input logic [POS_W-1:0] picb_q,
  input logic [4:0]       sr_q,
  input logic [4:0]       cr_q,
  input logic             nxt_ev,
  input logic             done_stb,
  input logic             done_ioc,
  input logic             fifo_err,
  input logic             irq
);

  p_rst_self_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cr_q[1] |=> !cr_q[1]);

  p_rst_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cr_q[1] |=> (base_q == 32'd0 && civ_q == '0 && lvi_q == '0 && piv_q == '0
                 && picb_q == '0 && !cr_q[0]));

  p_rst_keeps_enables_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cr_q[1] |=> cr_q[4:2] == $past(cr_q[4:2]));

  p_halt_tracks_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cr_q[0] |=> sr_q[0]);

  p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_ev |=> (civ_q == $past(piv_q) && piv_q == IDX_W'($past(piv_q) + 1'b1)));

  p_cmpl_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_stb && done_ioc) |=> sr_q[3]);

  p_fifo_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_err |=> sr_q[4]);

  p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cr_q[2] && !cr_q[4]) |-> !irq);

endmodule

bind adma_chan_regs adma_chan_regs_chk #(.IDX_W(IDX_W), .POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .base_q(base_q), .civ_q(civ_q), .lvi_q(lvi_q), .piv_q(piv_q),
  .picb_q(picb_q), .sr_q(sr_q), .cr_q(cr_q), .nxt_ev(nxt_ev), .done_stb(done_stb),
  .done_ioc(done_ioc), .fifo_err(fifo_err), .irq(irq)
);

// File: tb/adma_chan_regs_tb_top.sv
module adma_chan_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [3:0]  bus_be = 4'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        nxt_buf = 1'b0;
  logic [15:0] nxt_len = 16'h0;
  logic        smp_tick = 1'b0;
  logic        done_stb = 1'b0;
  logic        done_ioc = 1'b0;
  logic        fifo_err = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  adma_chan_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nxt_buf(nxt_buf), .nxt_len(nxt_len),
    .smp_tick(smp_tick), .done_stb(done_stb), .done_ioc(done_ioc), .fifo_err(fifo_err),
    .irq(irq)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_base;
  logic [4:0]  m_civ, m_lvi, m_piv, m_sr, m_cr;
  logic [15:0] m_picb;

  function automatic logic [31:0] m_read(input logic [3:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a[3:2])
      2'd0:    return m_base;
      2'd1:    return {11'h0, m_sr, 3'h0, m_lvi, 3'h0, m_civ};
      2'd2:    return {3'h0, m_cr, 3'h0, m_piv, m_picb};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic m_irq();
    return (m_sr[2] && m_cr[2]) || (m_sr[3] && m_cr[4]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_base = 0; m_civ = 0; m_lvi = 0; m_piv = 0; m_picb = 0; m_cr = 0; m_sr = 5'h01;
    end else begin
      bit rc, wok, lvw, nb, hit;
      logic [4:0] o_cr;
      logic [2:0] clr, setb;
      rc   = m_cr[1];
      o_cr = m_cr;
      wok  = bus_wr && !rc && bus_addr[1:0] == 2'b00;
      hit  = (m_civ == m_lvi);
      lvw  = wok && bus_addr[3:2] == 2'd1 && bus_be[1];
      nb   = nxt_buf && !rc;
      clr  = (wok && bus_addr[3:2] == 2'd1 && bus_be[2]) ? bus_wdata[20:18] : 3'b000;
      setb = {fifo_err, done_stb && done_ioc, done_stb && hit};
      // status
      m_sr[0] = !o_cr[0];
      if (done_stb && hit) m_sr[1] = 1'b1;
      else if (lvw || nb)  m_sr[1] = 1'b0;
      m_sr[4:2] = (m_sr[4:2] & ~clr) | setb;
      if (rc) begin
        m_base = 0; m_civ = 0; m_lvi = 0; m_piv = 0; m_picb = 0;
        m_cr = m_cr & 5'b11100;
      end else begin
        if (wok && bus_addr[3:2] == 2'd0)
          for (int b = 0; b < 4; b++) if (bus_be[b]) m_base[8*b +: 8] = bus_wdata[8*b +: 8];
        m_base[2:0] = 3'b000;
        if (lvw) m_lvi = bus_wdata[12:8];
        if (wok && bus_addr[3:2] == 2'd2 && bus_be[3]) m_cr = bus_wdata[28:24];
        if (nb) begin
          m_civ = m_piv;
          m_piv = m_piv + 5'd1;
          m_picb = nxt_len;
        end else if (smp_tick && m_picb != 0) begin
          m_picb = m_picb - 16'd1;
        end
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      chk({31'h0, irq}, {31'h0, m_irq()}, "R10 irq vs model");
      case (bus_addr[3:2])
        2'd0:    chk(bus_rdata, m_read(bus_addr), "R3 word 0x00 vs model");
        2'd1:    chk(bus_rdata, m_read(bus_addr), "R8 word 0x04 vs model");
        2'd2:    chk(bus_rdata, m_read(bus_addr), "R6 word 0x08 vs model");
        default: chk(bus_rdata, m_read(bus_addr), "R2 word 0x0C vs model");
      endcase
    end
  end

  task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic expect_word(input logic [3:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #2;
    chk(bus_rdata, e, tag);
  endtask

  task automatic expect_irq(input logic e, input string tag);
    @(posedge clk);
    #2;
    chk({31'h0, irq}, {31'h0, e}, tag);
  endtask

  task automatic pulse_nxt(input logic [15:0] len);
    @(negedge clk);
    nxt_buf = 1'b1; nxt_len = len;
    @(negedge clk);
    nxt_buf = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    smp_tick = 1'b1;
    @(negedge clk);
    smp_tick = 1'b0;
  endtask

  task automatic pulse_done(input logic ioc);
    @(negedge clk);
    done_stb = 1'b1; done_ioc = ioc;
    @(negedge clk);
    done_stb = 1'b0; done_ioc = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_word(4'h0, 32'h0000_0000, "R1 base after reset");
    expect_word(4'h4, 32'h0001_0000, "R1 status word after reset");
    expect_word(4'h8, 32'h0000_0000, "R1 control word after reset");
    expect_irq(1'b0, "R1 irq after reset");
    // R3 base writes
    wr(4'h0, 4'hF, 32'hDEAD_BEEF);
    expect_word(4'h0, 32'hDEAD_BEE8, "R3 base full write");
    wr(4'h0, 4'h1, 32'h1234_56FF);
    expect_word(4'h0, 32'hDEAD_BEF8, "R3 base byte 0 only");
    // R3/R4 read-only fields in word 0x04
    wr(4'h4, 4'hF, 32'hFFFF_FF07);
    expect_word(4'h4, 32'h0001_1F00, "R4 status 1:0 and civ ignore writes");
    wr(4'h4, 4'h2, 32'h0000_0200);
    wr(4'h8, 4'hF, 32'h15AB_CDEF);
    expect_word(4'h8, 32'h1500_0000, "R3 control write, piv/picb ignored");
    expect_word(4'h4, 32'h0000_0200, "R5 halted clears with run");
    // R6 / R7
    pulse_nxt(16'd100);
    expect_word(4'h8, 32'h1501_0064, "R6 advance loads position");
    expect_word(4'h4, 32'h0000_0200, "R6 civ takes piv");
    repeat (3) pulse_tick();
    expect_word(4'h8, 32'h1501_0061, "R7 position counts down");
    // R8 completion without last-valid match
    pulse_done(1'b1);
    expect_word(4'h4, 32'h0008_0200, "R8 completion sets bit 3");
    expect_irq(1'b1, "R10 irq from completion");
    // R4 W1C
    wr(4'h4, 4'h4, 32'h0008_0000);
    expect_word(4'h4, 32'h0000_0200, "R4 bit 3 cleared by one");
    expect_irq(1'b0, "R10 irq drops after clear");
    // R8 last-valid hit
    pulse_nxt(16'd5);
    pulse_nxt(16'd5);
    pulse_done(1'b0);
    expect_word(4'h4, 32'h0006_0202, "R8 last-valid hit sets bits 2 and 1");
    expect_irq(1'b1, "R10 irq from last-valid");
    // R4 set beats clear
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'h4; bus_be = 4'h4; bus_wdata = 32'h0004_0000;
    done_stb = 1'b1; done_ioc = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0; done_stb = 1'b0;
    expect_word(4'h4, 32'h0006_0202, "R4 set wins over clear");
    // R12 celv cleared by lvi write
    wr(4'h4, 4'h2, 32'h0000_0500);
    expect_word(4'h4, 32'h0004_0502, "R12 celv cleared by lvi write");
    // R9 / R10
    @(negedge clk); fifo_err = 1'b1;
    @(negedge clk); fifo_err = 1'b0;
    expect_word(4'h4, 32'h0014_0502, "R9 fifo error sets bit 4");
    wr(4'h4, 4'h4, 32'h0004_0000);
    wr(4'h8, 4'h8, 32'h1D00_0000);
    expect_word(4'h4, 32'h0010_0502, "R4 bit 2 cleared, bit 4 kept");
    expect_irq(1'b0, "R10 fifo error never raises irq");
    // R7 saturation
    repeat (7) pulse_tick();
    expect_word(4'h8, 32'h1D03_0000, "R7 position holds at zero");
    // R11 register reset
    wr(4'h8, 4'h8, 32'h1F00_0000);
    #1;
    chk({24'h0, bus_rdata[31:24]}, 32'h0000_001F, "R11 reset bit reads one");
    expect_word(4'h8, 32'h1C00_0000, "R11 reset clears, keeps enables");
    expect_word(4'h0, 32'h0000_0000, "R11 base cleared");
    expect_word(4'h4, 32'h0011_0000, "R11 indices cleared, halted back");
    // R6 wrap
    for (int i = 0; i < 32; i++) pulse_nxt(16'd7);
    expect_word(4'h8, 32'h1C00_0007, "R6 prefetched index wraps");
    expect_word(4'h4, 32'h0011_001F, "R6 civ reaches 31");
    // R13 misaligned
    expect_word(4'h5, 32'h0000_0000, "R13 misaligned read");
    wr(4'h9, 4'hF, 32'hFFFF_FFFF);
    expect_word(4'h8, 32'h1C00_0007, "R13 misaligned write ignored");
    expect_word(4'hC, 32'h0000_0000, "R2 spare word reads zero");
    // R11 bus write in reset cycle ignored
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'h8; bus_be = 4'h8; bus_wdata = 32'h0200_0000;
    @(negedge clk);
    bus_addr = 4'h4; bus_be = 4'h2; bus_wdata = 32'h0000_0900;
    @(negedge clk);
    bus_wr = 1'b0;
    expect_word(4'h4, 32'h0011_0000, "R11 write during reset cycle ignored");
    expect_word(4'h8, 32'h0000_0000, "R11 control after reset with no enables");
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule